// File: doc/BRIEF.md
# Direct-Mapped Instruction Translation Buffer

This block holds the address translations used by instruction fetch. It keeps 64 entries, chosen directly by a slice of the virtual page number. A fetch unit presents a 32-bit virtual address together with an enable. One clock later the block returns four results: whether the indexed entry matched, that entry's physical page number, its two execute permissions and its cache-inhibit attribute. The fetch unit and the exception logic around the block decide what to do with those results. They check the permissions against the current privilege mode and raise a miss or a fault. None of that is done here.

Software fills and inspects the entries through a special-register port made of chip-select, write-enable, a 32-bit register address and 32-bit data. Each entry has two halves, a match word (tag and valid) and a translate word (page number and attributes). The two halves sit in separate address windows. Read data comes back combinationally in the cycle chip-select is high. A write takes effect at the next clock edge and changes only the addressed half.

Top module: `itlb_dm`

## Requirements
- R1: An enabled lookup indexes entry vaddr[18:13] and compares the stored 13-bit tag with vaddr[31:19]. `hit` is 1 in the cycle after the request only if that entry is valid and the tags are equal; otherwise it is 0.
- R2: In the cycle after an enabled lookup, `ppn`, `uxe`, `sxe` and `ci` carry the indexed entry's stored page number and attribute bits.
- R3: Reset clears the valid bit of every entry. Until software programs an entry, no lookup of it hits and its match word reads with bit 0 equal to 0.
- R4: A cycle with `lookup_en` low drives `hit` to 0 in the following cycle, and `ppn`, `uxe`, `sxe` and `ci` keep their previous values.
- R5: Addresses 0x1200 to 0x123F select the match word of entry addr[5:0]. Its layout is tag in bits 31:19, valid in bit 0, and all other bits zero. Writing it changes only that entry's tag and valid bit.
- R6: Addresses 0x1300 to 0x133F select the translate word of entry addr[5:0]. Its layout is page number in bits 31:13, user-execute in bit 7, supervisor-execute in bit 6, cache-inhibit in bit 1, and all other bits zero. Writing it leaves the entry's tag and valid bit untouched.
- R7: `spr_rdata` gives the addressed word in the same cycle `spr_cs` is high. It is zero when `spr_cs` is low or when the address is outside both windows, and a write to an address outside both windows changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| lookup_en | input | 1 | Lookup request for this cycle |
| lookup_vaddr | input | 32 | Virtual fetch address |
| hit | output | 1 | Indexed entry valid and tag equal, one cycle after the request |
| ppn | output | 19 | Physical page number of the indexed entry |
| uxe | output | 1 | User-mode execute permission of the indexed entry |
| sxe | output | 1 | Supervisor-mode execute permission of the indexed entry |
| ci | output | 1 | Cache-inhibit attribute of the indexed entry |
| spr_cs | input | 1 | Special-register chip-select |
| spr_we | input | 1 | Special-register write-enable |
| spr_addr | input | 32 | Special-register address |
| spr_wdata | input | 32 | Special-register write data |
| spr_rdata | output | 32 | Special-register read data, combinational |

## Verification
Lookup results are registered once, so they are due one clock after the edge that samples `lookup_en`. The bench drives a request at a falling edge and reads `hit`, `ppn` and the attribute bits at the next falling edge. It then waits one more falling edge to check the hold and hit-drop behaviour. Register reads are combinational, so the bench samples `spr_rdata` 1 ns after it drives chip-select, still before the rising edge. Writes are driven across exactly one rising edge and are judged only through later reads or lookups.

// File: rtl/itlb_dm_pkg.sv
`timescale 1ns/1ps
package itlb_dm_pkg;

   // which special-register window an access falls in
   typedef enum logic [1:0] {
      WIN_NONE  = 2'd0,
      WIN_MATCH = 2'd1,
      WIN_XLATE = 2'd2
   } spr_win_e;

   // fixed low-order bit positions inside the two words
   localparam int VALID_POS = 0;
   localparam int CI_POS    = 1;
   localparam int SXE_POS   = 6;
   localparam int UXE_POS   = 7;

endpackage

// File: rtl/itlb_dm_spr_dec.sv
`timescale 1ns/1ps
module itlb_dm_spr_dec
   import itlb_dm_pkg::*;
#(
   parameter int AW       = 32,
   parameter int IDX_BITS = 6,
   parameter logic [AW-1:0] MATCH_BASE = 32'h0000_1200,
   parameter logic [AW-1:0] XLATE_BASE = 32'h0000_1300
) (
   input  logic                spr_cs,
   input  logic [AW-1:0]       spr_addr,
   output spr_win_e            win,
   output logic [IDX_BITS-1:0] idx
);
   localparam int HI_W = AW - IDX_BITS;

   logic [HI_W-1:0] addr_hi;
   logic            in_match;
   logic            in_xlate;

   assign addr_hi  = spr_addr[AW-1:IDX_BITS];
   assign idx      = spr_addr[IDX_BITS-1:0];
   assign in_match = (addr_hi == MATCH_BASE[AW-1:IDX_BITS]);
   assign in_xlate = (addr_hi == XLATE_BASE[AW-1:IDX_BITS]);

   always_comb begin
      win = WIN_NONE;
      if (spr_cs) begin
         if (in_match)      win = WIN_MATCH;
         else if (in_xlate) win = WIN_XLATE;
      end
   end

   initial begin
      base_align_chk: assert (MATCH_BASE[IDX_BITS-1:0] == '0 && XLATE_BASE[IDX_BITS-1:0] == '0)
         else $error("window bases must be aligned to the entry count");
      base_apart_chk: assert (MATCH_BASE[AW-1:IDX_BITS] != XLATE_BASE[AW-1:IDX_BITS])
         else $error("match and translate windows overlap");
   end
endmodule

// File: rtl/itlb_dm_store.sv
`timescale 1ns/1ps
module itlb_dm_store
   import itlb_dm_pkg::*;
#(
   parameter int DW       = 32,
   parameter int IDX_BITS = 6,
   parameter int TAG_W    = 13,
   parameter int PPN_W    = 19
) (
   input  logic                clk,
   input  logic                rst,
   // register-port side
   input  spr_win_e            win,
   input  logic                wr,
   input  logic [IDX_BITS-1:0] sp_idx,
   input  logic [DW-1:0]       wdata,
   output logic                sp_valid,
   output logic [TAG_W-1:0]    sp_tag,
   output logic [PPN_W-1:0]    sp_ppn,
   output logic                sp_uxe,
   output logic                sp_sxe,
   output logic                sp_ci,
   // lookup side
   input  logic [IDX_BITS-1:0] lk_idx,
   output logic                lk_valid,
   output logic [TAG_W-1:0]    lk_tag,
   output logic [PPN_W-1:0]    lk_ppn,
   output logic                lk_uxe,
   output logic                lk_sxe,
   output logic                lk_ci
);
   localparam int ENTRIES = 1 << IDX_BITS;

   logic [ENTRIES-1:0] valid_vec;
   logic [ENTRIES-1:0] uxe_vec;
   logic [ENTRIES-1:0] sxe_vec;
   logic [ENTRIES-1:0] ci_vec;
   logic [TAG_W-1:0]   tag_arr [ENTRIES];
   logic [PPN_W-1:0]   ppn_arr [ENTRIES];

   logic wr_match;
   logic wr_xlate;
   logic unused_wbits;

   assign wr_match     = wr && (win == WIN_MATCH);
   assign wr_xlate     = wr && (win == WIN_XLATE);
   assign unused_wbits = ^wdata;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic             sel;
      logic             v_q;
      logic [TAG_W-1:0] t_q;
      logic [PPN_W-1:0] p_q;
      logic             u_q;
      logic             s_q;
      logic             c_q;

      assign sel = (sp_idx == IDX_BITS'(e));

      always_ff @(posedge clk or posedge rst) begin
         if (rst)                 v_q <= 1'b0;
         else if (wr_match && sel) v_q <= wdata[VALID_POS];
      end

      always_ff @(posedge clk) begin
         if (wr_match && sel) t_q <= wdata[DW-1 -: TAG_W];
      end

      always_ff @(posedge clk) begin
         if (wr_xlate && sel) begin
            p_q <= wdata[DW-1 -: PPN_W];
            u_q <= wdata[UXE_POS];
            s_q <= wdata[SXE_POS];
            c_q <= wdata[CI_POS];
         end
      end

      assign valid_vec[e] = v_q;
      assign uxe_vec[e]   = u_q;
      assign sxe_vec[e]   = s_q;
      assign ci_vec[e]    = c_q;
      assign tag_arr[e]   = t_q;
      assign ppn_arr[e]   = p_q;
   end

   assign sp_valid = valid_vec[sp_idx];
   assign sp_tag   = tag_arr[sp_idx];
   assign sp_ppn   = ppn_arr[sp_idx];
   assign sp_uxe   = uxe_vec[sp_idx];
   assign sp_sxe   = sxe_vec[sp_idx];
   assign sp_ci    = ci_vec[sp_idx];

   assign lk_valid = valid_vec[lk_idx];
   assign lk_tag   = tag_arr[lk_idx];
   assign lk_ppn   = ppn_arr[lk_idx];
   assign lk_uxe   = uxe_vec[lk_idx];
   assign lk_sxe   = sxe_vec[lk_idx];
   assign lk_ci    = ci_vec[lk_idx];

   // R6
   xlate_keeps_valid_chk: assert property (@(posedge clk) disable iff (rst)
      wr_xlate |=> $stable(valid_vec));

   // R5
   match_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
      wr_match |=> (valid_vec[$past(sp_idx)] == $past(wdata[VALID_POS])));

   // R7
   foreign_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr && win == WIN_NONE) |=> $stable(valid_vec));
endmodule

// File: rtl/itlb_dm_lookup.sv
`timescale 1ns/1ps
module itlb_dm_lookup #(
   parameter int VPN_W    = 19,
   parameter int IDX_BITS = 6,
   parameter int TAG_W    = 13,
   parameter int PPN_W    = 19
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic [VPN_W-1:0]    vpn,
   output logic [IDX_BITS-1:0] idx,
   input  logic                e_valid,
   input  logic [TAG_W-1:0]    e_tag,
   input  logic [PPN_W-1:0]    e_ppn,
   input  logic                e_uxe,
   input  logic                e_sxe,
   input  logic                e_ci,
   output logic                hit,
   output logic [PPN_W-1:0]    ppn,
   output logic                uxe,
   output logic                sxe,
   output logic                ci
);
   logic [TAG_W-1:0] vtag;

   assign idx  = vpn[IDX_BITS-1:0];
   assign vtag = vpn[VPN_W-1:IDX_BITS];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         hit <= 1'b0;
         ppn <= '0;
         uxe <= 1'b0;
         sxe <= 1'b0;
         ci  <= 1'b0;
      end else if (en) begin
         hit <= e_valid && (e_tag == vtag);
         ppn <= e_ppn;
         uxe <= e_uxe;
         sxe <= e_sxe;
         ci  <= e_ci;
      end else begin
         hit <= 1'b0;
      end
   end

   // R4
   idle_drops_hit_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> !hit);

   // R4
   idle_holds_result_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(ppn) && $stable(uxe) && $stable(sxe) && $stable(ci)));

   // R1
   invalid_never_hits_chk: assert property (@(posedge clk) disable iff (rst)
      (en && !e_valid) |=> !hit);

   // R2
   result_follows_entry_chk: assert property (@(posedge clk) disable iff (rst)
      en |=> (ppn == $past(e_ppn)));
endmodule

// File: rtl/itlb_dm.sv
`timescale 1ns/1ps
module itlb_dm
   import itlb_dm_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int DW        = 32,
   parameter int PAGE_BITS = 13,
   parameter int IDX_BITS  = 6,
   parameter logic [VA_W-1:0] MATCH_BASE = 32'h0000_1200,
   parameter logic [VA_W-1:0] XLATE_BASE = 32'h0000_1300
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      lookup_en,
   input  logic [VA_W-1:0]           lookup_vaddr,
   output logic                      hit,
   output logic [VA_W-PAGE_BITS-1:0] ppn,
   output logic                      uxe,
   output logic                      sxe,
   output logic                      ci,
   input  logic                      spr_cs,
   input  logic                      spr_we,
   input  logic [VA_W-1:0]           spr_addr,
   input  logic [DW-1:0]             spr_wdata,
   output logic [DW-1:0]             spr_rdata
);
   localparam int VPN_W = VA_W - PAGE_BITS;
   localparam int PPN_W = VPN_W;
   localparam int TAG_W = VPN_W - IDX_BITS;

   initial begin
      width_match_chk: assert (DW == VA_W)
         else $error("data width must equal address width");
      tag_fits_chk: assert (TAG_W > 0 && TAG_W < DW)
         else $error("tag width out of range");
      ppn_fits_chk: assert (PPN_W <= DW - UXE_POS - 1)
         else $error("page number overlaps attribute bits");
   end

   spr_win_e            win;
   logic [IDX_BITS-1:0] sp_idx;
   logic [IDX_BITS-1:0] lk_idx;
   logic                sp_valid, sp_uxe, sp_sxe, sp_ci;
   logic [TAG_W-1:0]    sp_tag;
   logic [PPN_W-1:0]    sp_ppn;
   logic                lk_valid, lk_uxe, lk_sxe, lk_ci;
   logic [TAG_W-1:0]    lk_tag;
   logic [PPN_W-1:0]    lk_ppn;
   logic                unused_offset;

   assign unused_offset = ^lookup_vaddr[PAGE_BITS-1:0];

   itlb_dm_spr_dec #(
      .AW(VA_W), .IDX_BITS(IDX_BITS),
      .MATCH_BASE(MATCH_BASE), .XLATE_BASE(XLATE_BASE)
   ) u_dec (
      .spr_cs(spr_cs), .spr_addr(spr_addr), .win(win), .idx(sp_idx)
   );

   itlb_dm_store #(
      .DW(DW), .IDX_BITS(IDX_BITS), .TAG_W(TAG_W), .PPN_W(PPN_W)
   ) u_store (
      .clk(clk), .rst(rst),
      .win(win), .wr(spr_we), .sp_idx(sp_idx), .wdata(spr_wdata),
      .sp_valid(sp_valid), .sp_tag(sp_tag), .sp_ppn(sp_ppn),
      .sp_uxe(sp_uxe), .sp_sxe(sp_sxe), .sp_ci(sp_ci),
      .lk_idx(lk_idx),
      .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_ppn(lk_ppn),
      .lk_uxe(lk_uxe), .lk_sxe(lk_sxe), .lk_ci(lk_ci)
   );

   itlb_dm_lookup #(
      .VPN_W(VPN_W), .IDX_BITS(IDX_BITS), .TAG_W(TAG_W), .PPN_W(PPN_W)
   ) u_lookup (
      .clk(clk), .rst(rst), .en(lookup_en),
      .vpn(lookup_vaddr[VA_W-1:PAGE_BITS]), .idx(lk_idx),
      .e_valid(lk_valid), .e_tag(lk_tag), .e_ppn(lk_ppn),
      .e_uxe(lk_uxe), .e_sxe(lk_sxe), .e_ci(lk_ci),
      .hit(hit), .ppn(ppn), .uxe(uxe), .sxe(sxe), .ci(ci)
   );

   // read-back formatting: each half rebuilt into its register layout
   always_comb begin
      spr_rdata = '0;
      unique case (win)
         WIN_MATCH: begin
            spr_rdata[DW-1 -: TAG_W] = sp_tag;
            spr_rdata[VALID_POS]     = sp_valid;
         end
         WIN_XLATE: begin
            spr_rdata[DW-1 -: PPN_W] = sp_ppn;
            spr_rdata[UXE_POS]       = sp_uxe;
            spr_rdata[SXE_POS]       = sp_sxe;
            spr_rdata[CI_POS]        = sp_ci;
         end
         default: spr_rdata = '0;
      endcase
   end

   // R7
   idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !spr_cs |-> (spr_rdata == '0));

   // R7
   foreign_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (spr_cs && win == WIN_NONE) |-> (spr_rdata == '0));
endmodule

// File: tb/itlb_dm_test.sv
`timescale 1ns/1ps
module itlb_dm_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        lookup_en = 1'b0;
   logic [31:0] lookup_vaddr = '0;
   logic        hit, uxe, sxe, ci;
   logic [18:0] ppn;
   logic        spr_cs = 1'b0;
   logic        spr_we = 1'b0;
   logic [31:0] spr_addr = '0;
   logic [31:0] spr_wdata = '0;
   logic [31:0] spr_rdata;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   itlb_dm uut (
      .clk(clk), .rst(rst),
      .lookup_en(lookup_en), .lookup_vaddr(lookup_vaddr),
      .hit(hit), .ppn(ppn), .uxe(uxe), .sxe(sxe), .ci(ci),
      .spr_cs(spr_cs), .spr_we(spr_we), .spr_addr(spr_addr),
      .spr_wdata(spr_wdata), .spr_rdata(spr_rdata)
   );

   localparam logic [12:0] T5  = 13'h1ABC;
   localparam logic [18:0] P5  = 19'h5A5A5;
   localparam logic [18:0] P5B = 19'h13579;
   localparam logic [12:0] T0  = 13'h0F0F;
   localparam logic [18:0] P0  = 19'h00123;
   localparam logic [12:0] T63 = 13'h1FFF;
   localparam logic [18:0] P63 = 19'h6CDEF;

   function automatic logic [31:0] mword(input logic [12:0] t, input logic v);
      return {t, 18'd0, v};
   endfunction

   function automatic logic [31:0] xword(input logic [18:0] p, input logic u,
                                         input logic s, input logic c);
      return {p, 5'd0, u, s, 4'd0, c, 1'b0};
   endfunction

   function automatic logic [31:0] va(input logic [12:0] t, input logic [5:0] i,
                                      input logic [12:0] off);
      return {t, i, off};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic spr_wr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      spr_cs = 1'b1; spr_we = 1'b1; spr_addr = a; spr_wdata = d;
      @(negedge clk);
      spr_cs = 1'b0; spr_we = 1'b0;
   endtask

   task automatic spr_rd(input logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      spr_cs = 1'b1; spr_we = 1'b0; spr_addr = a;
      #1;
      d = spr_rdata;
      spr_cs = 1'b0;
   endtask

   // request at a falling edge; results are due at the next falling edge
   task automatic lookup(input logic [31:0] a);
      @(negedge clk);
      lookup_en = 1'b1; lookup_vaddr = a;
      @(negedge clk);
      lookup_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R3", "hit after reset", {31'd0, hit}, 32'd0);
      chk("R7", "rdata with cs low", spr_rdata, 32'd0);
      spr_rd(32'h1205, d);
      chk("R3", "valid bit after reset", {31'd0, d[0]}, 32'd0);
      lookup(va(T5, 6'd5, 13'h0010));
      chk("R3", "lookup before programming", {31'd0, hit}, 32'd0);
   endtask

   task automatic t_program();
      logic [31:0] d;
      spr_wr(32'h1205, mword(T5, 1'b1) | 32'h0007_FFFE);
      spr_rd(32'h1205, d);
      chk("R5", "match word read-back", d, mword(T5, 1'b1));
      spr_wr(32'h1305, xword(P5, 1'b1, 1'b1, 1'b1) | 32'h0000_1F3C);
      spr_rd(32'h1305, d);
      chk("R6", "translate word read-back", d, xword(P5, 1'b1, 1'b1, 1'b1));
   endtask

   task automatic t_hit_hold();
      lookup(va(T5, 6'd5, 13'h0ABC));
      chk("R1", "hit on programmed entry", {31'd0, hit}, 32'd1);
      chk("R2", "ppn", {13'd0, ppn}, {13'd0, P5});
      chk("R2", "attrs u/s/c", {29'd0, uxe, sxe, ci}, 32'd7);
      @(negedge clk);
      chk("R4", "hit dropped when idle", {31'd0, hit}, 32'd0);
      chk("R4", "ppn held when idle", {13'd0, ppn}, {13'd0, P5});
      chk("R4", "attrs held when idle", {29'd0, uxe, sxe, ci}, 32'd7);
   endtask

   task automatic t_miss();
      lookup(va(T5 ^ 13'h0001, 6'd5, 13'h0000));
      chk("R1", "tag mismatch misses", {31'd0, hit}, 32'd0);
      lookup(va(T5, 6'd6, 13'h0000));
      chk("R1", "other index misses", {31'd0, hit}, 32'd0);
   endtask

   task automatic t_bounds();
      logic [31:0] d;
      spr_wr(32'h1200, mword(T0, 1'b1));
      spr_wr(32'h1300, xword(P0, 1'b0, 1'b1, 1'b0));
      spr_wr(32'h123F, mword(T63, 1'b1));
      spr_wr(32'h133F, xword(P63, 1'b1, 1'b0, 1'b1));
      lookup(va(T0, 6'd0, 13'h1FFF));
      chk("R1", "entry 0 hit", {31'd0, hit}, 32'd1);
      chk("R2", "entry 0 ppn", {13'd0, ppn}, {13'd0, P0});
      chk("R2", "entry 0 attrs", {29'd0, uxe, sxe, ci}, 32'd2);
      lookup(va(T63, 6'd63, 13'h0000));
      chk("R1", "entry 63 hit", {31'd0, hit}, 32'd1);
      chk("R2", "entry 63 ppn", {13'd0, ppn}, {13'd0, P63});
      chk("R2", "entry 63 attrs", {29'd0, uxe, sxe, ci}, 32'd5);
      spr_rd(32'h123F, d);
      chk("R5", "entry 63 match word", d, mword(T63, 1'b1));
      spr_rd(32'h133F, d);
      chk("R6", "entry 63 translate word", d, xword(P63, 1'b1, 1'b0, 1'b1));
   endtask

   task automatic t_halves();
      logic [31:0] d;
      spr_wr(32'h1305, xword(P5B, 1'b0, 1'b1, 1'b0));
      lookup(va(T5, 6'd5, 13'h0004));
      chk("R6", "translate write keeps entry valid", {31'd0, hit}, 32'd1);
      chk("R6", "new ppn used", {13'd0, ppn}, {13'd0, P5B});
      chk("R6", "new attrs used", {29'd0, uxe, sxe, ci}, 32'd2);
      spr_rd(32'h1205, d);
      chk("R6", "match word untouched", d, mword(T5, 1'b1));
      spr_wr(32'h1205, mword(T5, 1'b0));
      lookup(va(T5, 6'd5, 13'h0004));
      chk("R5", "cleared valid misses", {31'd0, hit}, 32'd0);
      spr_rd(32'h1305, d);
      chk("R5", "translate word untouched", d, xword(P5B, 1'b0, 1'b1, 1'b0));
   endtask

   task automatic t_window();
      logic [31:0] d;
      spr_wr(32'h1240, 32'hFFFF_FFFF);
      spr_wr(32'h1340, 32'h0000_0000);
      spr_wr(32'h11C0, 32'h0000_0000);
      spr_rd(32'h1200, d);
      chk("R7", "entry 0 match after foreign writes", d, mword(T0, 1'b1));
      spr_rd(32'h1300, d);
      chk("R7", "entry 0 translate after foreign writes", d, xword(P0, 1'b0, 1'b1, 1'b0));
      spr_rd(32'h1240, d);
      chk("R7", "read outside windows", d, 32'd0);
      spr_rd(32'h1280, d);
      chk("R7", "read between windows", d, 32'd0);
      lookup(va(T0, 6'd0, 13'h0000));
      chk("R7", "entry 0 still hits", {31'd0, hit}, 32'd1);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_program();
      t_hit_hold();
      t_miss();
      t_bounds();
      t_halves();
      t_window();
      @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule